// File: doc/BRIEF.md
# Byte-Wide Instruction Prefetch Unit

This block is the bus-side front end of a small processor. It reads instruction bytes ahead of need into a four-entry byte queue, while an execution unit takes bytes from the queue's head through a valid/ready handshake. All memory traffic goes over a narrow external bus. Each bus cycle takes four clocks and moves one byte. The address and the write data share the same output lines.

The execution unit can also issue single-byte data reads and writes. These share the bus with prefetch and win arbitration at every cycle boundary. A jump is signalled with a one-clock flush pulse that carries the target address. The flush empties the queue, throws away the byte of any fetch that is still running, and restarts sequential fetching at the target. Whether the consumer stalls on an empty queue, or the bus idles on a full one, depends on how fast the consumer drains the queue.

Top module: `byte_prefetch_unit`

## Requirements
- R1: While reset is high and in the first clock after it, `ib_valid_o`, `da_done_o`, `bus_ale_o`, `bus_rd_o` and `bus_wr_o` are low. The first bus cycle after reset is a fetch from parameter `RESET_ADDR` (default 0xFFFF0).
- R2: Every bus cycle is exactly four clocks long. The first clock is the address clock (`bus_ale_o` high). The next three are strobe clocks, with `bus_rd_o` high for fetches and reads and `bus_wr_o` high for writes. A new cycle may follow with no gap.
- R3: Bytes leave the queue in order of increasing address, one byte per rising edge at which `ib_valid_o` and `ib_ready_i` are both high. Each byte has the address one above the previous byte.
- R4: A fetch cycle starts only when the bytes in the queue plus the fetch already in flight number fewer than four. With no consumer, exactly four fetch cycles run after a flush and the bus then stays idle.
- R5: `ib_valid_o` is low whenever the queue is empty. After a flush taken while the bus is idle, the first byte becomes visible five clocks after the flush edge.
- R6: A flush sampled at a rising edge empties the queue, discards the byte of any fetch in progress, starts no bus cycle on that edge, and makes fetching continue from `flush_addr_i`.
- R7: During the address clock, `bus_ad_o` carries the full 20-bit address. During the strobe clocks of a write, it carries the write byte in bits 7:0 with all upper bits zero. `bus_fetch_o` is high for all four clocks of a fetch cycle and low for data cycles.
- R8: A data request that is pending when a bus cycle ends, or while the bus is idle, starts the next bus cycle ahead of any prefetch. Bytes already queued are not affected.
- R9: A data read returns the `bus_din_i` value present in its last strobe clock on `da_rdata_o`. `da_done_o` is high for exactly one clock after a data cycle ends. The requester drops `da_req_i` in that clock.
- R10: The fetch address wraps from 0xFFFFF to 0x00000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_i | input | 1 | One-clock restart pulse |
| flush_addr_i | input | 20 | Restart fetch address |
| ib_ready_i | input | 1 | Consumer takes the head byte |
| ib_valid_o | output | 1 | Queue head byte is valid |
| ib_byte_o | output | 8 | Queue head byte |
| da_req_i | input | 1 | Data access request, held until done |
| da_we_i | input | 1 | 1 = write, 0 = read |
| da_addr_i | input | 20 | Data access address |
| da_wdata_i | input | 8 | Write byte |
| da_done_o | output | 1 | Data access finished (one clock) |
| da_rdata_o | output | 8 | Read byte |
| bus_ale_o | output | 1 | Address clock marker |
| bus_rd_o | output | 1 | Read strobe |
| bus_wr_o | output | 1 | Write strobe |
| bus_fetch_o | output | 1 | Current cycle is an instruction fetch |
| bus_ad_o | output | 20 | Multiplexed address / write data |
| bus_din_i | input | 8 | Read data from memory |

## Verification
The embedded assertions check these rules on every clock:
- every address clock is followed by a strobe clock and not by another address clock;
- a fetch never starts and a byte is never pushed while the queue, counting the fetch in flight, is full;
- a flush leaves the queue empty on the next clock;
- a pending data request always takes the cycle that follows a fetch;
- `da_done_o` never lasts two clocks.

The bench scenarios are needed for the rest:
- the actual byte values and their address order, including the wrap;
- the exact four-fetch fill and five-clock restart latency;
- that a discarded fetch never surfaces;
- that data reads and writes place the right values on the shared lines.

// File: rtl/pfu_pkg.sv
package pfu_pkg;
  typedef enum logic [2:0] {PH_IDLE, PH_T1, PH_T2, PH_T3, PH_T4} bus_phase_e;
  typedef enum logic [1:0] {CYC_FETCH, CYC_READ, CYC_WRITE} cyc_kind_e;
endpackage

// File: rtl/pfu_byte_queue.sv
module pfu_byte_queue #(
  parameter int DW    = 8,
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         clear_i,
  input  logic                         push_i,
  input  logic [DW-1:0]                push_data_i,
  input  logic                         pop_i,
  output logic [DW-1:0]                head_o,
  output logic [$clog2(DEPTH+1)-1:0]   count_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count_q;
  logic          pop_ok, push_ok;

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign pop_ok  = pop_i && (count_q != '0);
  assign push_ok = push_i && ((count_q != CW'(DEPTH)) || pop_ok);

  // storage without reset so it maps onto distributed or block RAM
  always_ff @(posedge clk) begin
    if (push_ok && !clear_i) mem[wr_ptr] <= push_data_i;
  end

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_q <= '0;
    end else begin
      if (push_ok) wr_ptr <= ptr_next(wr_ptr);
      if (pop_ok)  rd_ptr <= ptr_next(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  assign head_o  = mem[rd_ptr];
  assign count_o = count_q;

  // R4: the room rule upstream must never let a byte arrive at a full queue
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    (push_i && !clear_i) |-> (count_q != CW'(DEPTH)));
endmodule

// File: rtl/pfu_bus_seq.sv
module pfu_bus_seq
  import pfu_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  cyc_kind_e     start_kind_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic [DW-1:0] start_wdata_i,
  output bus_phase_e    phase_o,
  output cyc_kind_e     kind_o,
  output logic          slot_o,
  output logic          end_o,
  output logic          ale_o,
  output logic          rd_o,
  output logic          wr_o,
  output logic          fetch_o,
  output logic [AW-1:0] ad_o
);
  bus_phase_e    phase_q;
  cyc_kind_e     kind_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          strobe;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      kind_q  <= CYC_FETCH;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      unique case (phase_q)
        PH_T1: phase_q <= PH_T2;
        PH_T2: phase_q <= PH_T3;
        PH_T3: phase_q <= PH_T4;
        default: begin
          if (start_i) begin
            phase_q <= PH_T1;
            kind_q  <= start_kind_i;
            addr_q  <= start_addr_i;
            wdata_q <= start_wdata_i;
          end else begin
            phase_q <= PH_IDLE;
          end
        end
      endcase
    end
  end

  assign slot_o  = (phase_q == PH_IDLE) || (phase_q == PH_T4);
  assign end_o   = (phase_q == PH_T4);
  assign strobe  = (phase_q == PH_T2) || (phase_q == PH_T3) || (phase_q == PH_T4);
  assign ale_o   = (phase_q == PH_T1);
  assign rd_o    = strobe && (kind_q != CYC_WRITE);
  assign wr_o    = strobe && (kind_q == CYC_WRITE);
  assign fetch_o = (phase_q != PH_IDLE) && (kind_q == CYC_FETCH);
  assign phase_o = phase_q;
  assign kind_o  = kind_q;

  always_comb begin
    ad_o = '0;
    if (phase_q == PH_T1)                   ad_o = addr_q;
    else if (strobe && kind_q == CYC_WRITE) ad_o = AW'(wdata_q);
  end

  // R2: the arbiter may only launch a cycle at a cycle boundary
  assert_start_in_slot_R2: assert property (@(posedge clk) disable iff (rst)
    start_i |-> slot_o);
endmodule

// File: rtl/byte_prefetch_unit.sv
module byte_prefetch_unit
  import pfu_pkg::*;
#(
  parameter int          AW         = 20,
  parameter int          DW         = 8,
  parameter int          QDEPTH     = 4,
  parameter logic [19:0] RESET_ADDR = 20'hFFFF0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush_i,
  input  logic [AW-1:0] flush_addr_i,
  input  logic          ib_ready_i,
  output logic          ib_valid_o,
  output logic [DW-1:0] ib_byte_o,
  input  logic          da_req_i,
  input  logic          da_we_i,
  input  logic [AW-1:0] da_addr_i,
  input  logic [DW-1:0] da_wdata_i,
  output logic          da_done_o,
  output logic [DW-1:0] da_rdata_o,
  output logic          bus_ale_o,
  output logic          bus_rd_o,
  output logic          bus_wr_o,
  output logic          bus_fetch_o,
  output logic [AW-1:0] bus_ad_o,
  input  logic [DW-1:0] bus_din_i
);
  localparam int CW = $clog2(QDEPTH+1);

  bus_phase_e    phase;
  cyc_kind_e     kind, start_kind;
  logic          slot, cyc_end, busy, inflight, room;
  logic          data_block, data_go, start, push;
  logic [AW-1:0] fetch_addr_q, start_addr;
  logic          discard_q, done_q;
  logic [DW-1:0] rdata_q;
  logic [CW-1:0] q_count;

  // ---- arbitration: data first, prefetch only with guaranteed room ----
  assign busy       = (phase != PH_IDLE);
  assign inflight   = busy && (kind == CYC_FETCH) && !discard_q;
  assign room       = (int'(q_count) + int'(inflight)) < QDEPTH;
  assign data_block = done_q || (cyc_end && kind != CYC_FETCH);
  assign data_go    = da_req_i && !data_block;
  assign start      = slot && !flush_i && (data_go || room);
  assign start_kind = !data_go ? CYC_FETCH : (da_we_i ? CYC_WRITE : CYC_READ);
  assign start_addr = data_go ? da_addr_i : fetch_addr_q;
  assign push       = cyc_end && (kind == CYC_FETCH) && !discard_q && !flush_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_addr_q <= AW'(RESET_ADDR);
      discard_q    <= 1'b0;
      done_q       <= 1'b0;
      rdata_q      <= '0;
    end else begin
      if (flush_i)                fetch_addr_q <= flush_addr_i;
      else if (start && !data_go) fetch_addr_q <= fetch_addr_q + 1'b1;

      if (flush_i)      discard_q <= busy && !cyc_end && (kind == CYC_FETCH);
      else if (cyc_end) discard_q <= 1'b0;

      done_q <= cyc_end && (kind != CYC_FETCH);
      if (cyc_end && kind == CYC_READ) rdata_q <= bus_din_i;
    end
  end

  pfu_bus_seq #(.AW(AW), .DW(DW)) seq_i (
    .clk(clk), .rst(rst),
    .start_i(start), .start_kind_i(start_kind),
    .start_addr_i(start_addr), .start_wdata_i(da_wdata_i),
    .phase_o(phase), .kind_o(kind), .slot_o(slot), .end_o(cyc_end),
    .ale_o(bus_ale_o), .rd_o(bus_rd_o), .wr_o(bus_wr_o),
    .fetch_o(bus_fetch_o), .ad_o(bus_ad_o)
  );

  pfu_byte_queue #(.DW(DW), .DEPTH(QDEPTH)) queue_i (
    .clk(clk), .rst(rst), .clear_i(flush_i),
    .push_i(push), .push_data_i(bus_din_i),
    .pop_i(ib_ready_i),
    .head_o(ib_byte_o), .count_o(q_count)
  );

  assign ib_valid_o = (q_count != '0);
  assign da_done_o  = done_q;
  assign da_rdata_o = rdata_q;

  // R2: an address clock is always followed by a strobe clock
  assert_addr_then_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    bus_ale_o |=> (!bus_ale_o && (bus_rd_o || bus_wr_o)));
  // R4: a fetch in its address clock always has a free queue slot
  assert_fetch_has_room_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_ale_o && bus_fetch_o) |-> (q_count < CW'(QDEPTH)));
  // R6: queue is empty the clock after a flush
  assert_flush_empties_R6: assert property (@(posedge clk) disable iff (rst)
    flush_i |=> !ib_valid_o);
  // R8: a pending data request takes the cycle following a fetch
  assert_data_priority_R8: assert property (@(posedge clk) disable iff (rst)
    (cyc_end && kind == CYC_FETCH && da_req_i && !done_q && !flush_i)
      |=> (bus_ale_o && !bus_fetch_o));
  // R9: completion is a single-clock pulse
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    da_done_o |=> !da_done_o);
endmodule

// File: tb/byte_prefetch_unit_tb_top.sv
module byte_prefetch_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flush_i = 1'b0;
  logic [19:0] flush_addr_i = '0;
  logic        ib_ready_i = 1'b0;
  logic        ib_valid_o;
  logic [7:0]  ib_byte_o;
  logic        da_req_i = 1'b0, da_we_i = 1'b0;
  logic [19:0] da_addr_i = '0;
  logic [7:0]  da_wdata_i = '0;
  logic        da_done_o;
  logic [7:0]  da_rdata_o;
  logic        bus_ale_o, bus_rd_o, bus_wr_o, bus_fetch_o;
  logic [19:0] bus_ad_o;
  logic [7:0]  bus_din_i;

  int checks = 0, failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  byte_prefetch_unit dut_i (
    .clk(clk), .rst(rst), .flush_i(flush_i), .flush_addr_i(flush_addr_i),
    .ib_ready_i(ib_ready_i), .ib_valid_o(ib_valid_o), .ib_byte_o(ib_byte_o),
    .da_req_i(da_req_i), .da_we_i(da_we_i), .da_addr_i(da_addr_i),
    .da_wdata_i(da_wdata_i), .da_done_o(da_done_o), .da_rdata_o(da_rdata_o),
    .bus_ale_o(bus_ale_o), .bus_rd_o(bus_rd_o), .bus_wr_o(bus_wr_o),
    .bus_fetch_o(bus_fetch_o), .bus_ad_o(bus_ad_o), .bus_din_i(bus_din_i)
  );

  function automatic logic [7:0] mem_byte(input logic [19:0] a);
    return a[7:0] + {a[19:16], a[15:12]} + 8'h3C;
  endfunction

  // memory model and bus monitor, sampled mid-cycle
  logic [19:0] lat_addr = '0, last_ale_addr = '0;
  logic        last_ale_fetch = 1'b0, wr_seen = 1'b0;
  logic [7:0]  last_wdata = '0;
  int          ale_count = 0;
  assign bus_din_i = mem_byte(lat_addr);

  always @(negedge clk) begin
    if (bus_ale_o) begin
      lat_addr       <= bus_ad_o;
      last_ale_addr  <= bus_ad_o;
      last_ale_fetch <= bus_fetch_o;
      ale_count      <= ale_count + 1;
    end
    if (bus_wr_o) begin
      wr_seen    <= 1'b1;
      last_wdata <= bus_ad_o[7:0];
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_flush(input logic [19:0] a);
    @(negedge clk); flush_i = 1'b1; flush_addr_i = a;
    @(negedge clk); flush_i = 1'b0;
  endtask

  task automatic wait_ale();
    int w = 0;
    @(negedge clk);
    while (!bus_ale_o && w < 100) begin @(negedge clk); w++; end
  endtask

  task automatic consume(input logic [19:0] base, input int n, input string req);
    ib_ready_i = 1'b0;
    for (int i = 0; i < n; i++) begin
      int w = 0;
      while (!ib_valid_o && w < 200) begin @(negedge clk); w++; end
      chk(ib_valid_o && ib_byte_o == mem_byte(base + 20'(i)), req,
          ib_byte_o, mem_byte(base + 20'(i)));
      ib_ready_i = 1'b1;
      @(negedge clk);
      ib_ready_i = 1'b0;
    end
  endtask

  task automatic data_access(input bit we, input logic [19:0] a, input logic [7:0] d);
    int w = 0;
    da_we_i = we; da_addr_i = a; da_wdata_i = d; da_req_i = 1'b1;
    @(negedge clk);
    while (!da_done_o && w < 100) begin @(negedge clk); w++; end
    da_req_i = 1'b0;
  endtask

  // stimulus table: restart address and bytes to take; expected bytes follow mem_byte
  localparam int NT = 5;
  localparam logic [19:0] T_ADDR [NT] = '{20'h00000, 20'h12345, 20'hFFFFE, 20'h0ABCD, 20'h7FFFF};
  localparam int          T_NUM  [NT] = '{6, 5, 4, 3, 2};

  initial begin
    // R1 reset state
    repeat (3) begin
      @(negedge clk);
      chk(!ib_valid_o && !da_done_o && !bus_ale_o && !bus_rd_o && !bus_wr_o,
          "R1 reset outputs", {ib_valid_o, da_done_o, bus_ale_o, bus_rd_o, bus_wr_o}, 0);
    end
    rst = 1'b0;
    @(negedge clk);
    chk(!ib_valid_o && !bus_rd_o && !bus_wr_o, "R1 first clock", ib_valid_o, 0);
    if (!bus_ale_o) wait_ale();
    chk(bus_ale_o && bus_fetch_o && bus_ad_o == 20'hFFFF0, "R1 R7 first fetch address",
        bus_ad_o, 20'hFFFF0);
    // R2: three strobe clocks follow the address clock
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(bus_rd_o && !bus_ale_o && !bus_wr_o && bus_fetch_o, "R2 strobe clocks",
          {bus_ale_o, bus_rd_o, bus_wr_o}, 3'b010);
    end
    @(negedge clk);
    chk(bus_ale_o, "R2 back-to-back next cycle", bus_ale_o, 1);
    consume(20'hFFFF0, 3, "R3 sequence after reset");

    // table walk: R3 ordering, R6 restart, R10 wrap
    for (int t = 0; t < NT; t++) begin
      do_flush(T_ADDR[t]);
      chk(!ib_valid_o, "R6 queue empty after flush", ib_valid_o, 0);
      consume(T_ADDR[t], T_NUM[t], (T_ADDR[t] == 20'hFFFFE) ? "R10 wrap" : "R3 table");
    end

    // R4 full: exactly four fetches, then idle
    begin
      int base;
      do_flush(20'h40000);
      base = ale_count;
      repeat (40) @(negedge clk);
      chk(ale_count - base == 4, "R4 fetches until full", ale_count - base, 4);
      base = ale_count;
      repeat (40) @(negedge clk);
      chk(ale_count == base && !bus_rd_o, "R4 bus idle when full", ale_count - base, 0);
      chk(ib_valid_o && ib_byte_o == mem_byte(20'h40000), "R4 head byte kept",
          ib_byte_o, mem_byte(20'h40000));
    end

    // R5 empty stall and restart latency from idle bus
    begin
      int lat = 0;
      do_flush(20'h50000);
      while (!ib_valid_o && lat < 50) begin @(negedge clk); lat++; end
      chk(lat == 5, "R5 first byte latency", lat, 5);
      consume(20'h50000, 4, "R3 R5 bytes after restart");
    end

    // R6 flush while a fetch is running
    do_flush(20'h22222);
    repeat (2) @(negedge clk);
    do_flush(20'h33330);
    consume(20'h33330, 4, "R6 discarded fetch never seen");

    // R9 data read and R7 write on an idle bus with full queue
    do_flush(20'h0C000);
    repeat (30) @(negedge clk);
    data_access(1'b0, 20'h9A5C3, 8'h00);
    chk(da_done_o && da_rdata_o == mem_byte(20'h9A5C3), "R9 read data",
        da_rdata_o, mem_byte(20'h9A5C3));
    chk(last_ale_addr == 20'h9A5C3 && !last_ale_fetch, "R7 read address on bus",
        last_ale_addr, 20'h9A5C3);
    @(negedge clk);
    chk(!da_done_o, "R9 done one clock", da_done_o, 0);
    wr_seen = 1'b0;
    data_access(1'b1, 20'h01234, 8'hC7);
    chk(wr_seen && last_wdata == 8'hC7, "R7 write data on bus", last_wdata, 8'hC7);
    chk(last_ale_addr == 20'h01234, "R7 write address on bus", last_ale_addr, 20'h01234);
    consume(20'h0C000, 4, "R8 queue untouched by data cycles");

    // R8 priority: request raised during a fetch wins the next cycle
    do_flush(20'h60000);
    wait_ale();
    da_we_i = 1'b0; da_addr_i = 20'h00777; da_req_i = 1'b1;
    wait_ale();
    chk(!bus_fetch_o && bus_ad_o == 20'h00777, "R8 data before next fetch",
        bus_ad_o, 20'h00777);
    begin
      int w = 0;
      while (!da_done_o && w < 20) begin @(negedge clk); w++; end
    end
    da_req_i = 1'b0;
    chk(da_rdata_o == mem_byte(20'h00777), "R9 read after priority", da_rdata_o,
        mem_byte(20'h00777));
    consume(20'h60000, 3, "R8 fetch stream resumes");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule